// File: doc/BRIEF.md
# ATM Cell Label-Swap Switch

This block sits on one link of a cell switch and rewrites the routing label of each passing 53-byte cell. Cells arrive one byte per clock on a valid/ready stream, with a start marker on the first byte. The block holds the five header bytes, reads the path and channel identifiers, and searches a small connection table. On a hit, it writes the next-hop identifiers into the header and sends the cell out with the output port from the entry. On a miss, it takes in the whole cell and drops it, with no notification. The remaining header fields and all 48 payload bytes pass through unchanged.

The link runs in one of two header formats, selected by a mode input. In user-side format, the path identifier is 8 bits and a 4-bit flow-control nibble sits ahead of it. In network-side format, that nibble becomes the top four bits of a 12-bit path identifier. A write port loads table entries. Two saturating counters report forwarded and dropped cells, and each counter has its own clear strobe.

Top module: `atm_label_switch`

## Requirements
- R1: After reset, `out_valid` is low, `in_ready` is high and both counters read zero.
- R2: With `nni_mode` low, the path identifier is 8 bits: byte 0 bits 3:0 are its high nibble and byte 1 bits 7:4 are its low nibble. The channel identifier is 16 bits: byte 1 bits 3:0, then byte 2, then byte 3 bits 7:4. On a hit, only these bits are replaced; only the low 8 bits of the replacement path value are used. Byte 0 bits 7:4, byte 3 bits 3:0, byte 4 and all 48 payload bytes are copied unchanged.
- R3: With `nni_mode` high, the path identifier is 12 bits, taking all of byte 0 and byte 1 bits 7:4. A hit replaces all 12 bits.
- R4: In user-side mode, the 8-bit incoming path value is zero-extended before comparison. An entry whose match path value has any bit above bit 7 set never matches, whatever the flow-control nibble holds.
- R5: Entries whose valid bit is clear are ignored. When several valid entries match, the one with the lowest index supplies the replacement and the port.
- R6: A cell with no matching entry has all 53 bytes accepted. No byte of it is emitted, and the drop counter rises by one.
- R7: A forwarded cell leaves as exactly 53 bytes, with `out_sof` high only on its first byte. `out_port` holds the entry's port on every byte, and the forward counter rises by one.
- R8: No output byte of a cell is presented while its five header bytes are still being accepted.
- R9: A table write takes effect for cells whose first byte is accepted on a later clock edge than the write. A write on the same edge as the first byte, or during the cell, does not change that cell's outcome.
- R10: While waiting for a cell, bytes without `in_sof` are accepted and discarded, with no output and no counter change. Inside a cell, `in_sof` is ignored and the byte is treated as data.
- R11: The counters are `CNT_W` bits wide (32 by default) and stop at all ones. A clear strobe sets its counter to zero and leaves the other unchanged.
- R12: With `out_ready` low, the emitted byte is held and no data is lost. During the payload, `in_ready` follows `out_ready`.
- R13: While the table is unchanged, the same incoming identifier pair always gives the same rewritten header and port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nni_mode | input | 1 | 1 = network-side header format, 0 = user-side; held stable during a cell |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_sof | input | 1 | Input byte is the first byte of a cell |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_sof | output | 1 | Output byte is the first byte of a cell |
| out_data | output | 8 | Output byte |
| out_port | output | 2 | Egress port tag of the current cell |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | log2(N_ENTRIES) | Entry index to write |
| cfg_vld | input | 1 | Valid bit for the written entry |
| cfg_match_vpi | input | 12 | Incoming path identifier to match |
| cfg_match_vci | input | 16 | Incoming channel identifier to match |
| cfg_new_vpi | input | 12 | Replacement path identifier |
| cfg_new_vci | input | 16 | Replacement channel identifier |
| cfg_port | input | 2 | Output port for the entry |
| clr_fwd | input | 1 | Clear the forward counter |
| clr_drop | input | 1 | Clear the drop counter |
| fwd_cnt | output | CNT_W | Forwarded cell count |
| drop_cnt | output | CNT_W | Dropped cell count |

## Verification
The bench sends cells in both header formats. It uses identifiers at their extremes (all ones, all zeros), a user-side cell whose flow-control nibble equals the upper bits of a stored network-side entry, two valid entries with the same label, and a label held only by an invalid entry. Together these separate correct field slicing from a shifted slice, zero-extension from a comparison that includes the nibble, and lowest-index priority from highest-index priority.

Cells run with the output both always ready and stalled every third cycle, which exposes lost or repeated bytes. Table writes are placed on the first-byte edge and in mid-header, to fix the edge at which a new entry starts to count. Stray bytes before a cell and a start marker in the middle of a payload test the framing.

// File: rtl/atm_xlate_pkg.sv
`timescale 1ns/1ps
package atm_xlate_pkg;
  localparam int VPI_W      = 12;
  localparam int VCI_W      = 16;
  localparam int PORT_W     = 2;
  localparam int HDR_BYTES  = 5;
  localparam int PAY_BYTES  = 48;

  typedef logic [HDR_BYTES-1:0][7:0] hdr_t;

  typedef struct packed {
    logic              vld;
    logic [VPI_W-1:0]  m_vpi;
    logic [VCI_W-1:0]  m_vci;
    logic [VPI_W-1:0]  n_vpi;
    logic [VCI_W-1:0]  n_vci;
    logic [PORT_W-1:0] port;
  } entry_t;

  typedef enum logic [2:0] {
    PH_HUNT, PH_HDR, PH_LOOK, PH_SEND, PH_PASS, PH_SKIP
  } phase_t;

  // path label from the header; user-side format zero-extends 8 bits
  function automatic logic [VPI_W-1:0] hdr_vpi(hdr_t h, logic nni);
    if (nni) return {h[0], h[1][7:4]};
    return {4'b0000, h[0][3:0], h[1][7:4]};
  endfunction

  function automatic logic [VCI_W-1:0] hdr_vci(hdr_t h);
    return {h[1][3:0], h[2], h[3][7:4]};
  endfunction

  // write new label bits, keep flow-control nibble (user side), PT/CLP, HEC
  function automatic hdr_t hdr_swap(hdr_t h, logic nni,
                                    logic [VPI_W-1:0] vpi,
                                    logic [VCI_W-1:0] vci);
    hdr_t r;
    r    = h;
    r[0] = nni ? vpi[11:4] : {h[0][7:4], vpi[7:4]};
    r[1] = {vpi[3:0], vci[15:12]};
    r[2] = vci[11:4];
    r[3] = {vci[3:0], h[3][3:0]};
    return r;
  endfunction
endpackage

// File: rtl/atm_sat_counter.sv
`timescale 1ns/1ps
module atm_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  wire at_top = (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (inc && !at_top) cnt <= cnt + 1'b1;
  end

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R11
  AST_CNT_HOLD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && !clr) |=> (cnt == TOP)); // R11
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !at_top) |=> (cnt == $past(cnt) + 1'b1)); // R6
endmodule

// File: rtl/atm_label_table.sv
`timescale 1ns/1ps
module atm_label_table
  import atm_xlate_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  entry_t            wentry,
  input  logic              snap_en,
  input  logic [VPI_W-1:0]  key_vpi,
  input  logic [VCI_W-1:0]  key_vci,
  output logic              hit,
  output logic [VPI_W-1:0]  win_vpi,
  output logic [VCI_W-1:0]  win_vci,
  output logic [PORT_W-1:0] win_port
);
  entry_t live_q [N_ENTRIES];
  entry_t snap_q [N_ENTRIES];
  logic [N_ENTRIES-1:0] mvec;
  logic [N_ENTRIES-1:0] below_mask;
  logic [IDX_W-1:0]     win_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        live_q[i] <= '0;
        snap_q[i] <= '0;
      end
    end else begin
      if (we) live_q[widx] <= wentry;
      // lookup uses the table as it stood when the cell's first byte arrived
      if (snap_en) begin
        for (int i = 0; i < N_ENTRIES; i++) snap_q[i] <= live_q[i];
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_ENTRIES; g++) begin : g_cmp
      assign mvec[g] = snap_q[g].vld && (snap_q[g].m_vpi == key_vpi)
                       && (snap_q[g].m_vci == key_vci);
    end
  endgenerate

  always_comb begin
    hit     = 1'b0;
    win_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (mvec[i]) begin
        hit     = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end

  assign win_vpi    = snap_q[win_idx].n_vpi;
  assign win_vci    = snap_q[win_idx].n_vci;
  assign win_port   = snap_q[win_idx].port;
  assign below_mask = (N_ENTRIES'(1) << win_idx) - N_ENTRIES'(1);

  AST_WIN_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (mvec[win_idx] && ((mvec & below_mask) == '0))); // R5
  AST_MISS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (mvec == '0)); // R5
endmodule

// File: rtl/atm_cell_engine.sv
`timescale 1ns/1ps
module atm_cell_engine
  import atm_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nni_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sof,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sof,
  output logic [7:0]        out_data,
  output logic [PORT_W-1:0] out_port,
  output logic              snap_en,
  output logic [VPI_W-1:0]  key_vpi,
  output logic [VCI_W-1:0]  key_vci,
  input  logic              hit,
  input  logic [VPI_W-1:0]  win_vpi,
  input  logic [VCI_W-1:0]  win_vci,
  input  logic [PORT_W-1:0] win_port,
  output logic              ev_hit,
  output logic              ev_miss
);
  localparam int CW = $clog2(PAY_BYTES);
  localparam logic [CW-1:0] LAST_PAY = CW'(PAY_BYTES - 1);
  localparam logic [CW-1:0] LAST_HDR = CW'(HDR_BYTES - 1);
  localparam int OBW = $clog2(HDR_BYTES + PAY_BYTES);
  localparam logic [OBW-1:0] LAST_OUT = OBW'(HDR_BYTES + PAY_BYTES - 1);

  phase_t            ph_q;
  logic [CW-1:0]     cnt_q;
  hdr_t              hbuf_q;
  logic [PORT_W-1:0] port_q;

  wire in_hs   = in_valid && in_ready;
  wire out_hs  = out_valid && out_ready;
  wire ev_cell_end = ((ph_q == PH_PASS) || (ph_q == PH_SKIP)) && in_hs
                     && (cnt_q == LAST_PAY);

  assign snap_en  = (ph_q == PH_HUNT) && in_valid && in_sof;
  assign key_vpi  = hdr_vpi(hbuf_q, nni_mode);
  assign key_vci  = hdr_vci(hbuf_q);
  assign ev_hit   = (ph_q == PH_LOOK) && hit;
  assign ev_miss  = (ph_q == PH_LOOK) && !hit;
  assign out_port = port_q;

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_sof   = 1'b0;
    out_data  = in_data;
    unique case (ph_q)
      PH_HUNT, PH_HDR, PH_SKIP: in_ready = 1'b1;
      PH_SEND: begin
        out_valid = 1'b1;
        out_sof   = (cnt_q == '0);
        out_data  = hbuf_q[cnt_q[2:0]];
      end
      PH_PASS: begin
        in_ready  = out_ready;
        out_valid = in_valid;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_HUNT;
      cnt_q  <= '0;
      hbuf_q <= '0;
      port_q <= '0;
    end else begin
      unique case (ph_q)
        PH_HUNT: if (snap_en) begin
          hbuf_q[0] <= in_data;
          cnt_q     <= CW'(1);
          ph_q      <= PH_HDR;
        end
        PH_HDR: if (in_hs) begin
          hbuf_q[cnt_q[2:0]] <= in_data;
          if (cnt_q == LAST_HDR) begin
            cnt_q <= '0;
            ph_q  <= PH_LOOK;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_LOOK: begin
          cnt_q <= '0;
          if (hit) begin
            hbuf_q <= hdr_swap(hbuf_q, nni_mode, win_vpi, win_vci);
            port_q <= win_port;
            ph_q   <= PH_SEND;
          end else ph_q <= PH_SKIP;
        end
        PH_SEND: if (out_hs) begin
          if (cnt_q == LAST_HDR) begin
            cnt_q <= '0;
            ph_q  <= PH_PASS;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_PASS, PH_SKIP: if (in_hs) begin
          if (cnt_q == LAST_PAY) begin
            cnt_q <= '0;
            ph_q  <= PH_HUNT;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: ph_q <= PH_HUNT;
      endcase
    end
  end

  // observation state for the assertions
  logic [OBW-1:0] ob_cnt_q;
  logic           dropping_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ob_cnt_q   <= '0;
      dropping_q <= 1'b0;
    end else begin
      if (out_hs) ob_cnt_q <= (ob_cnt_q == LAST_OUT) ? '0 : ob_cnt_q + 1'b1;
      if (ev_miss) dropping_q <= 1'b1;
      else if (ev_cell_end) dropping_q <= 1'b0;
    end
  end

  AST_SOF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    out_hs |-> (out_sof == (ob_cnt_q == '0))); // R7
  AST_PORT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_PASS) |-> $stable(out_port)); // R7
  AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_SEND) && !out_ready) |=> (out_valid && $stable(out_data))); // R12
  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !dropping_q); // R6
endmodule

// File: rtl/atm_label_switch.sv
`timescale 1ns/1ps
module atm_label_switch
  import atm_xlate_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int CNT_W     = 32,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nni_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sof,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sof,
  output logic [7:0]        out_data,
  output logic [PORT_W-1:0] out_port,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_vld,
  input  logic [VPI_W-1:0]  cfg_match_vpi,
  input  logic [VCI_W-1:0]  cfg_match_vci,
  input  logic [VPI_W-1:0]  cfg_new_vpi,
  input  logic [VCI_W-1:0]  cfg_new_vci,
  input  logic [PORT_W-1:0] cfg_port,
  input  logic              clr_fwd,
  input  logic              clr_drop,
  output logic [CNT_W-1:0]  fwd_cnt,
  output logic [CNT_W-1:0]  drop_cnt
);
  entry_t            wentry;
  logic              snap_en, hit, ev_hit, ev_miss;
  logic [VPI_W-1:0]  key_vpi, win_vpi;
  logic [VCI_W-1:0]  key_vci, win_vci;
  logic [PORT_W-1:0] win_port;

  assign wentry = '{vld: cfg_vld, m_vpi: cfg_match_vpi, m_vci: cfg_match_vci,
                    n_vpi: cfg_new_vpi, n_vci: cfg_new_vci, port: cfg_port};

  atm_label_table #(.N_ENTRIES(N_ENTRIES)) u_table (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .widx(cfg_idx), .wentry(wentry),
    .snap_en(snap_en), .key_vpi(key_vpi), .key_vci(key_vci), .hit(hit),
    .win_vpi(win_vpi), .win_vci(win_vci), .win_port(win_port)
  );

  atm_cell_engine u_engine (
    .clk(clk), .rst_n(rst_n), .nni_mode(nni_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_sof(out_sof),
    .out_data(out_data), .out_port(out_port),
    .snap_en(snap_en), .key_vpi(key_vpi), .key_vci(key_vci), .hit(hit),
    .win_vpi(win_vpi), .win_vci(win_vci), .win_port(win_port),
    .ev_hit(ev_hit), .ev_miss(ev_miss)
  );

  atm_sat_counter #(.W(CNT_W)) u_fwd_cnt (
    .clk(clk), .rst_n(rst_n), .inc(ev_hit), .clr(clr_fwd), .cnt(fwd_cnt)
  );

  atm_sat_counter #(.W(CNT_W)) u_drop_cnt (
    .clk(clk), .rst_n(rst_n), .inc(ev_miss), .clr(clr_drop), .cnt(drop_cnt)
  );
endmodule

// File: tb/test_atm_label_switch.sv
`timescale 1ns/1ps
module test_atm_label_switch;
  localparam int CW = 4;
  localparam int NV = 9;
  localparam int WATCHDOG = 150000;

  logic clk = 0, rst_n = 0;
  logic nni_mode = 0, in_valid = 0, in_sof = 0, out_ready = 1;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, out_sof;
  logic [7:0] out_data;
  logic [1:0] out_port;
  logic cfg_we = 0, cfg_vld = 0, clr_fwd = 0, clr_drop = 0;
  logic [3:0] cfg_idx = 0;
  logic [11:0] cfg_match_vpi = 0, cfg_new_vpi = 0;
  logic [15:0] cfg_match_vci = 0, cfg_new_vci = 0;
  logic [1:0] cfg_port = 0;
  logic [CW-1:0] fwd_cnt, drop_cnt;

  atm_label_switch #(.CNT_W(CW)) i_atm_label_switch (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, rcnt = 0;
  bit stall = 0;
  int exp_fwd = 0, exp_drop = 0;
  logic [7:0] mon_buf [64];
  bit mon_sof [64];
  logic [1:0] mon_port [64];
  int mon_n = 0;

  // vectors: nni, gfc, vpi, vci, pt/clp, hit, port, new vpi, new vci, stall
  localparam bit          V_NNI  [NV] = '{0, 0, 1, 0, 1, 0, 0, 1, 0};
  localparam logic [3:0]  V_GFC  [NV] = '{4'h3, 4'hC, 4'h0, 4'h1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h3};
  localparam logic [11:0] V_VPI  [NV] = '{12'h005, 12'h0FF, 12'hABC, 12'h022, 12'h122,
                                          12'h033, 12'h066, 12'h005, 12'h005};
  localparam logic [15:0] V_VCI  [NV] = '{16'h0023, 16'hFFFF, 16'h0100, 16'h0777, 16'h0777,
                                          16'h0044, 16'h0066, 16'h0023, 16'h0023};
  localparam logic [3:0]  V_PTC  [NV] = '{4'hA, 4'h1, 4'h6, 4'h2, 4'hF, 4'h0, 4'h3, 4'h9, 4'hA};
  localparam bit          V_HIT  [NV] = '{1, 1, 1, 0, 1, 1, 0, 1, 1};
  localparam logic [1:0]  V_PORT [NV] = '{2'd1, 2'd2, 2'd3, 2'd0, 2'd0, 2'd1, 2'd0, 2'd1, 2'd1};
  localparam logic [11:0] V_NVPI [NV] = '{12'h07A, 12'hF01, 12'h123, 12'h000, 12'h0AA,
                                          12'h055, 12'h000, 12'h07A, 12'h07A};
  localparam logic [15:0] V_NVCI [NV] = '{16'h1234, 16'h0000, 16'hBEEF, 16'h0000, 16'h0BBB,
                                          16'h0055, 16'h0000, 16'h1234, 16'h1234};
  localparam bit          V_STL  [NV] = '{0, 1, 0, 1, 1, 0, 0, 1, 1};
  localparam string       V_TAG  [NV] = '{"R2", "R2", "R3", "R4", "R3", "R5", "R5", "R3", "R13"};

  function automatic logic [39:0] mk_hdr(bit nni, logic [3:0] gfc, logic [11:0] vpi,
                                         logic [15:0] vci, logic [3:0] ptc, logic [7:0] hec);
    if (nni) return {vpi, vci, ptc, hec};
    return {gfc, vpi[7:0], vci, ptc, hec};
  endfunction

  function automatic int sat_inc(int v);
    return (v >= (1 << CW) - 1) ? v : v + 1;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    rcnt++;
    out_ready = stall ? ((rcnt % 3) != 0) : 1'b1;
  end

  always begin
    @(negedge clk);
    #5;
    if (out_valid && out_ready) begin
      if (mon_n < 64) begin
        mon_buf[mon_n]  = out_data;
        mon_sof[mon_n]  = out_sof;
        mon_port[mon_n] = out_port;
      end
      mon_n++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic cfg_write(int idx, bit v, logic [11:0] mv, logic [15:0] mc,
                           logic [11:0] nv, logic [15:0] nc, logic [1:0] p, bit pulse);
    @(negedge clk);
    cfg_idx = 4'(idx); cfg_vld = v; cfg_match_vpi = mv; cfg_match_vci = mc;
    cfg_new_vpi = nv; cfg_new_vci = nc; cfg_port = p;
    if (pulse) begin
      cfg_we = 1;
      @(negedge clk);
      cfg_we = 0;
    end
  endtask

  // drives one cell; returns 1 in early if out_valid rose during the header
  task automatic send_cell(logic [39:0] hdr, logic [7:0] seed, int wr_at, int sof_at,
                           output bit early);
    early = 0;
    for (int i = 0; i < 53; i++) begin
      @(negedge clk);
      cfg_we   = (i == wr_at);
      in_valid = 1;
      in_sof   = (i == 0) || (i == sof_at);
      in_data  = (i < 5) ? hdr[39 - 8*i -: 8] : 8'(seed + 8'(i));
      #5;
      while (!in_ready) begin
        @(negedge clk);
        cfg_we = 0;
        #5;
      end
      if (i < 5 && out_valid) early = 1;
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; cfg_we = 0;
  endtask

  task automatic run_cell(bit nni, logic [3:0] gfc, logic [11:0] vpi, logic [15:0] vci,
                          logic [3:0] ptc, bit hit, logic [1:0] port, logic [11:0] nvpi,
                          logic [15:0] nvci, bit stl, logic [7:0] seed, int wr_at,
                          int sof_at, string tag);
    logic [39:0] ih, eh;
    bit early;
    int bad, badsof, badport;
    logic [7:0] exp_b;
    ih = mk_hdr(nni, gfc, vpi, vci, ptc, seed ^ 8'h5A);
    eh = mk_hdr(nni, gfc, nvpi, nvci, ptc, seed ^ 8'h5A);
    nni_mode = nni;
    stall = stl;
    mon_n = 0;
    send_cell(ih, seed, wr_at, sof_at, early);
    repeat (3) @(negedge clk);
    stall = 0;
    if (hit) begin
      exp_fwd = sat_inc(exp_fwd);
      chk(mon_n == 53, tag, "R7 emitted byte count", mon_n, 53);
      bad = 0; badsof = 0; badport = 0;
      for (int k = 0; k < 53 && k < mon_n; k++) begin
        exp_b = (k < 5) ? eh[39 - 8*k -: 8] : 8'(seed + 8'(k));
        if (mon_buf[k] !== exp_b) begin
          if (bad == 0) $display("  byte %0d got %0h want %0h", k, mon_buf[k], exp_b);
          bad++;
        end
        if (mon_sof[k] !== (k == 0)) badsof++;
        if (mon_port[k] !== port) badport++;
      end
      chk(bad == 0, tag, "rewritten cell bytes mismatched", bad, 0);
      chk(badsof == 0, tag, "R7 sof misplaced count", badsof, 0);
      chk(badport == 0, tag, "R7 out_port wrong count", badport, 0);
      chk(!early, tag, "R8 output during header", early, 0);
    end else begin
      exp_drop = sat_inc(exp_drop);
      chk(mon_n == 0, tag, "R6 dropped cell emitted bytes", mon_n, 0);
    end
    chk(fwd_cnt == CW'(exp_fwd), tag, "R7 forward count", fwd_cnt, exp_fwd);
    chk(drop_cnt == CW'(exp_drop), tag, "R6 drop count", drop_cnt, exp_drop);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #5;
    chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
    chk(fwd_cnt == 0 && drop_cnt == 0, "R1", "counters after reset",
        {fwd_cnt, drop_cnt}, 0);

    cfg_write(0, 1, 12'h005, 16'h0023, 12'h07A, 16'h1234, 2'd1, 1);
    cfg_write(1, 1, 12'h0FF, 16'hFFFF, 12'hF01, 16'h0000, 2'd2, 1);
    cfg_write(2, 1, 12'hABC, 16'h0100, 12'h123, 16'hBEEF, 2'd3, 1);
    cfg_write(4, 1, 12'h122, 16'h0777, 12'h0AA, 16'h0BBB, 2'd0, 1);
    cfg_write(5, 1, 12'h033, 16'h0044, 12'h055, 16'h0055, 2'd1, 1);
    cfg_write(6, 1, 12'h033, 16'h0044, 12'h099, 16'h0099, 2'd2, 1);
    cfg_write(7, 0, 12'h066, 16'h0066, 12'h0C0, 16'h0C0C, 2'd3, 1);

    for (int v = 0; v < NV; v++)
      run_cell(V_NNI[v], V_GFC[v], V_VPI[v], V_VCI[v], V_PTC[v], V_HIT[v], V_PORT[v],
               V_NVPI[v], V_NVCI[v], V_STL[v], 8'(16 * v + 3), -1, -1, V_TAG[v]);

    // R10: stray bytes while waiting for a cell start
    mon_n = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1; in_sof = 0; in_data = 8'(8'hE0 + i);
      #5;
      chk(in_ready == 1, "R10", "stray byte not accepted", in_ready, 1);
    end
    @(negedge clk); in_valid = 0;
    repeat (3) @(negedge clk);
    chk(mon_n == 0, "R10", "stray bytes emitted", mon_n, 0);
    chk(fwd_cnt == CW'(exp_fwd) && drop_cnt == CW'(exp_drop), "R10",
        "stray bytes moved counters", {fwd_cnt, drop_cnt}, {CW'(exp_fwd), CW'(exp_drop)});
    // R10: start marker inside the payload is data
    run_cell(0, 4'h3, 12'h005, 16'h0023, 4'hA, 1, 2'd1, 12'h07A, 16'h1234, 0,
             8'h70, -1, 20, "R10");

    // R9: validating entry 7 mid-header does not rescue the cell in flight
    cfg_write(7, 1, 12'h066, 16'h0066, 12'h0C0, 16'h0C0C, 2'd3, 0);
    run_cell(0, 4'h0, 12'h066, 16'h0066, 4'h3, 0, 2'd0, 12'h0, 16'h0, 0,
             8'h81, 2, -1, "R9");
    run_cell(0, 4'h0, 12'h066, 16'h0066, 4'h3, 1, 2'd3, 12'h0C0, 16'h0C0C, 0,
             8'h82, -1, -1, "R9");
    // R9: invalidating on the same edge as the first byte keeps the old entry
    cfg_write(7, 0, 12'h066, 16'h0066, 12'h0C0, 16'h0C0C, 2'd3, 0);
    run_cell(0, 4'h0, 12'h066, 16'h0066, 4'h3, 1, 2'd3, 12'h0C0, 16'h0C0C, 1,
             8'h83, 0, -1, "R9");
    run_cell(0, 4'h0, 12'h066, 16'h0066, 4'h3, 0, 2'd0, 12'h0, 16'h0, 0,
             8'h84, -1, -1, "R9");

    // R11: clear, then saturate
    @(negedge clk); clr_fwd = 1;
    @(negedge clk); clr_fwd = 0; exp_fwd = 0;
    #5;
    chk(fwd_cnt == 0, "R11", "forward count after clear", fwd_cnt, 0);
    chk(drop_cnt == CW'(exp_drop), "R11", "drop count after other clear", drop_cnt, exp_drop);
    for (int n = 0; n < 17; n++)
      run_cell(1, 4'h0, 12'hABC, 16'h0100, 4'h6, 1, 2'd3, 12'h123, 16'hBEEF, 0,
               8'(n), -1, -1, "R11");
    chk(fwd_cnt == '1, "R11", "forward count saturated", fwd_cnt, (1 << CW) - 1);
    @(negedge clk); clr_drop = 1;
    @(negedge clk); clr_drop = 0; exp_drop = 0;
    #5;
    chk(drop_cnt == 0, "R11", "drop count after clear", drop_cnt, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule